// File: doc/BRIEF.md
# Programmable Synthesizer Divider and Phase Comparator

This block is the digital core of a frequency synthesizer loop. A main divider counts edges of the prescaled RF clock and a reference divider counts edges of the reference input. A phase/frequency comparator then looks at which divider reaches its terminal count first, and it drives pump-up or pump-down controls for as long as the two terminal events are apart. The analog charge pump, loop filter, oscillator and prescaler are outside the block.

Both clocks reach the block as one-cycle tick strobes in a single fast clock domain. The main ratio is a fixed base of 2176 plus a 7-bit offset, so any ratio from 2176 to 2303 can be set. At the nominal 864 kHz comparison rate this gives an output of 0.864 MHz times the ratio. The reference ratio is 4, 8, 12 or 16, chosen by a 2-bit code whose encoding is not in numeric order. Raising the enable starts both dividers and the comparator together from a known phase. Lowering it lets any pump pulse already in progress run to its end. The block then goes idle at the next reference terminal count, so the reference ticks must keep arriving after disable. All pins are plain control and status levels. There is no streamed data and so no valid/ready handshake.

Top module: `synth_core`

## Requirements
- R1: While active, `main_pulse` rises once every 2176+n `rf_tick` strobes, where n is `main_ofs` read as a 7-bit unsigned value. The first pulse follows the (2176+n)-th tick counted after the clock edge that starts the block.
- R2: While active, `ref_pulse` rises once every R `ref_tick` strobes, with `ref_code` 2'b00 giving R=4, 2'b10 giving R=8, 2'b11 giving R=12 and 2'b01 giving R=16.
- R3: A new `main_ofs` or `ref_code` takes effect only when the divider reloads at its terminal count. The count in progress always finishes with the ratio it started with.
- R4: Each divider terminal pulse is high for exactly one clock.
- R5: If `main_pulse` comes before `ref_pulse`, `pump_dn` is high from the clock after the main pulse through the clock of the reference pulse. Its length in clocks equals the gap between the two pulses, and `pump_up` stays low.
- R6: If `ref_pulse` comes before `main_pulse`, `pump_up` is high in the same way, for the gap between the pulses, and `pump_dn` stays low.
- R7: If both terminal pulses fall in the same clock, neither pump output goes high.
- R8: `pump_up` and `pump_dn` are never high in the same clock.
- R9: When `synth_en` is sampled high while the block is idle, `active` is high from the next clock. Both dividers then count from their full ratio and the comparator starts clear.
- R10: While `active` is low, both divider pulses and both pump outputs stay low, whatever the tick inputs do.
- R11: After `synth_en` is sampled low, a pump pulse already high runs to its normal end and no new pump pulse starts. The dividers keep counting. `active` falls in the clock after the first `ref_pulse` that comes with both pump outputs low.
- R12: After reset, `active`, both divider pulses and both pump outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rf_tick | input | 1 | One-cycle strobe per prescaled RF edge |
| ref_tick | input | 1 | One-cycle strobe per reference input edge |
| synth_en | input | 1 | Synthesizer run request |
| main_ofs | input | 7 | Main ratio offset n, ratio 2176+n |
| ref_code | input | 2 | Reference ratio code |
| main_pulse | output | 1 | Main divider terminal pulse |
| ref_pulse | output | 1 | Reference divider terminal pulse |
| pump_up | output | 1 | Charge-pump source control |
| pump_dn | output | 1 | Charge-pump sink control |
| active | output | 1 | Synthesizer running or draining |

## Verification
Two pairs of events can fall in the same clock. The first pair is the two divider terminal counts. A zero reference phase offset puts both pulses in one clock, and the bench expects no pump pulse at all. The second pair is the disable and a pump pulse still in progress. The enable is dropped a few clocks after a main terminal pulse, and the bench expects the in-flight pump pulse to keep its full predicted length. It also expects no pump pulse on the next main edge and `active` to fall exactly one clock after the following reference pulse. In one case that stopping reference pulse coincides with a main terminal pulse.

// File: rtl/synth_pkg.sv
package synth_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } syn_state_e;

  // Multiple of the reference unit ratio selected by the 2-bit code.
  // The code order is not numeric: 00->1, 10->2, 11->3, 01->4.
  function automatic int unsigned ref_mult(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b10:   return 2;
      2'b11:   return 3;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/syn_cycle_div.sv
module syn_cycle_div #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hold,
  input  logic             mute,
  input  logic [CNT_W-1:0] load_val,
  output logic             term
);

  logic [CNT_W-1:0] cnt;
  logic             at_zero;

  assign at_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      term <= 1'b0;
    end else begin
      term <= tick & at_zero & ~hold & ~mute;
      if (hold) begin
        cnt <= load_val;
      end else if (tick) begin
        // The ratio is read only here, at the terminal count.
        if (at_zero) cnt <= load_val;
        else         cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/syn_pfd.sv
module syn_pfd (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic allow_start,
  input  logic ev_main,
  input  logic ev_ref,
  output logic up,
  output logic dn
);

  logic set_up, set_dn, nx_up, nx_dn, both;

  // An edge may open a new pulse only while running. While draining,
  // an edge can still close a pulse already open on the other side.
  assign set_up = ev_ref  & (allow_start | dn);
  assign set_dn = ev_main & (allow_start | up);
  assign nx_up  = up | set_up;
  assign nx_dn  = dn | set_dn;
  assign both   = nx_up & nx_dn;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= nx_up & ~both;
      dn <= nx_dn & ~both;
    end
  end

endmodule

// File: rtl/syn_ctl.sv
module syn_ctl
  import synth_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ev_ref,
  input  logic up,
  input  logic dn,
  output logic hold,
  output logic mute,
  output logic allow_start,
  output logic active
);

  syn_state_e st, st_nx;
  logic       stop_now;

  assign stop_now = (st == ST_DRAIN) & ev_ref & ~up & ~dn;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  if (en)       st_nx = ST_RUN;
      ST_RUN:   if (!en)      st_nx = ST_DRAIN;
      ST_DRAIN: if (stop_now) st_nx = ST_IDLE;
      default:                st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign hold        = (st == ST_IDLE);
  assign mute        = stop_now;
  assign allow_start = (st == ST_RUN);
  assign active      = (st != ST_IDLE);

endmodule

// File: rtl/synth_core.sv
module synth_core
  import synth_pkg::*;
#(
  parameter int MAIN_BASE = 2176,
  parameter int OFS_W     = 7,
  parameter int REF_UNIT  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rf_tick,
  input  logic             ref_tick,
  input  logic             synth_en,
  input  logic [OFS_W-1:0] main_ofs,
  input  logic [1:0]       ref_code,
  output logic             main_pulse,
  output logic             ref_pulse,
  output logic             pump_up,
  output logic             pump_dn,
  output logic             active
);

  localparam int MAIN_CNT_W = $clog2(MAIN_BASE + (1 << OFS_W));
  localparam int REF_CNT_W  = $clog2(4 * REF_UNIT);

  logic [MAIN_CNT_W-1:0] main_load;
  logic [REF_CNT_W-1:0]  ref_load;
  logic                  hold, mute, allow_start;

  assign main_load = MAIN_CNT_W'(MAIN_BASE - 1) + MAIN_CNT_W'(main_ofs);
  assign ref_load  = REF_CNT_W'(REF_UNIT * ref_mult(ref_code) - 1);

  syn_cycle_div #(.CNT_W(MAIN_CNT_W)) u_main_div (
    .clk(clk), .rst_n(rst_n), .tick(rf_tick), .hold(hold), .mute(mute),
    .load_val(main_load), .term(main_pulse)
  );

  syn_cycle_div #(.CNT_W(REF_CNT_W)) u_ref_div (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .hold(hold), .mute(mute),
    .load_val(ref_load), .term(ref_pulse)
  );

  syn_pfd u_pfd (
    .clk(clk), .rst_n(rst_n), .clr(hold), .allow_start(allow_start),
    .ev_main(main_pulse), .ev_ref(ref_pulse), .up(pump_up), .dn(pump_dn)
  );

  syn_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .en(synth_en), .ev_ref(ref_pulse),
    .up(pump_up), .dn(pump_dn), .hold(hold), .mute(mute),
    .allow_start(allow_start), .active(active)
  );

endmodule

// File: rtl/synth_core_chk.sv
module synth_core_chk (
  input logic clk,
  input logic rst_n,
  input logic synth_en,
  input logic main_pulse,
  input logic ref_pulse,
  input logic pump_up,
  input logic pump_dn,
  input logic active
);

  AST_PUMP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn)); // R8

  AST_MAIN_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    main_pulse |=> !main_pulse); // R4

  AST_REF_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!main_pulse && !ref_pulse && !pump_up && !pump_dn)); // R10

  AST_START_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && synth_en) |=> active); // R9

  AST_REF_ENDS_DN: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_dn && ref_pulse) |=> !pump_dn); // R5

  AST_MAIN_ENDS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_up && main_pulse) |=> !pump_up); // R6

  AST_SAME_CLK_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (main_pulse && ref_pulse && !pump_up && !pump_dn) |=> (!pump_up && !pump_dn)); // R7

  AST_DRAIN_NO_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (!synth_en && $past(!synth_en) && !pump_up && !pump_dn) |=> (!pump_up && !pump_dn)); // R11

endmodule

bind synth_core synth_core_chk u_chk (.*);

// File: tb/sim_synth_core.sv
module sim_synth_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rf_tick = 1'b0;
  logic       ref_tick = 1'b0;
  logic       synth_en = 1'b0;
  logic [6:0] main_ofs = '0;
  logic [1:0] ref_code = '0;
  logic       main_pulse, ref_pulse, pump_up, pump_dn, active;

  always #5 clk = ~clk;

  synth_core u0 (
    .clk(clk), .rst_n(rst_n), .rf_tick(rf_tick), .ref_tick(ref_tick),
    .synth_en(synth_en), .main_ofs(main_ofs), .ref_code(ref_code),
    .main_pulse(main_pulse), .ref_pulse(ref_pulse),
    .pump_up(pump_up), .pump_dn(pump_dn), .active(active)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int exp_main[$], exp_ref[$], exp_pump[$];

  task automatic fail(input string req, input int act, input int exp);
    n_fail++;
    $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Reference tick generator, driven away from the active edge.
  bit ref_on = 1'b0;
  int ref_base = 0, ref_q = 1;
  always @(negedge clk) begin
    int d;
    d = cyc + 1 - ref_base;
    ref_tick <= ref_on && (d > 0) && (d % ref_q == 0);
  end

  // Monitor: pops expected items as results appear.
  bit mon_on = 1'b0, prev_main = 1'b0, prev_ref = 1'b0;
  int up_len = 0, dn_len = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (main_pulse) begin
        n_chk++;
        if (prev_main) fail("R4 main", 1, 0);
        if (exp_main.size() == 0) fail("R1 R3 R10 stray main", cyc, -1);
        else begin int e; e = exp_main.pop_front(); if (cyc != e) fail("R1 R3 main", cyc, e); end
      end
      if (ref_pulse) begin
        n_chk++;
        if (prev_ref) fail("R4 ref", 1, 0);
        if (exp_ref.size() == 0) fail("R2 R10 stray ref", cyc, -1);
        else begin int e; e = exp_ref.pop_front(); if (cyc != e) fail("R2 ref", cyc, e); end
      end
      if (pump_up && pump_dn) fail("R8 both pumps", 1, 0);
      if (pump_up) up_len++;
      else if (up_len > 0) begin
        n_chk++;
        if (exp_pump.size() == 0) fail("R6 R7 R11 stray up", -up_len, 0);
        else begin int e; e = exp_pump.pop_front(); if (e != -up_len) fail("R6 up length", -up_len, e); end
        up_len = 0;
      end
      if (pump_dn) dn_len++;
      else if (dn_len > 0) begin
        n_chk++;
        if (exp_pump.size() == 0) fail("R5 R7 R11 stray dn", dn_len, 0);
        else begin int e; e = exp_pump.pop_front(); if (e != dn_len) fail("R5 dn length", dn_len, e); end
        dn_len = 0;
      end
      prev_main = main_pulse;
      prev_ref  = ref_pulse;
    end
  end

  task automatic wait_cyc(input int t);
    do @(negedge clk); while (cyc < t);
  endtask

  function automatic int ref_div(input logic [1:0] c);
    case (c)
      2'b00:   return 4;
      2'b10:   return 8;
      2'b11:   return 12;
      default: return 16;
    endcase
  endfunction

  // Driver: one enable/disable run with predicted pulse times.
  task automatic scen(input int n0, input logic [1:0] code, input int q, input int off,
                      input int kmax, input int chg_k, input int n_new, input int dd);
    int c0, rr, s;
    int mt[8];
    int ft[8];
    rr = ref_div(code);
    @(negedge clk);
    main_ofs = 7'(n0);
    ref_code = code;
    rf_tick  = 1'b1;
    c0       = cyc + 5;
    ref_base = c0 + off;
    ref_q    = q;
    ref_on   = 1'b1;
    mt[0] = c0;
    for (int k = 1; k <= kmax + 1; k++) begin
      mt[k] = mt[k-1] + ((chg_k > 0 && k >= chg_k + 2) ? 2176 + n_new : 2176 + n0);
      ft[k] = ref_base + k * rr * q;
    end
    for (int k = 1; k <= kmax; k++) begin
      exp_main.push_back(mt[k]);
      exp_ref.push_back(ft[k]);
      if (ft[k] != mt[k]) exp_pump.push_back(ft[k] - mt[k]);
    end
    s = ft[kmax + 1];
    exp_ref.push_back(s);
    if (mt[kmax + 1] <= s) exp_main.push_back(mt[kmax + 1]);
    wait_cyc(c0 - 1);
    synth_en = 1'b1;
    wait_cyc(c0);
    n_chk++;
    if (active !== 1'b1) fail("R9 active after start", active, 1);
    if (chg_k > 0) begin
      wait_cyc(mt[chg_k]);
      main_ofs = 7'(n_new);
    end
    wait_cyc(mt[kmax] + dd);
    synth_en = 1'b0;
    wait_cyc(s);
    n_chk++;
    if (active !== 1'b1) fail("R11 active held while draining", active, 1);
    wait_cyc(s + 1);
    n_chk++;
    if (active !== 1'b0) fail("R11 active after stop", active, 0);
    wait_cyc(s + 300);
    ref_on = 1'b0;
    n_chk++;
    if (exp_main.size() + exp_ref.size() + exp_pump.size() != 0)
      fail("R1 R2 R5 R6 missing events", exp_main.size() + exp_ref.size() + exp_pump.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if ({active, main_pulse, ref_pulse, pump_up, pump_dn} !== 5'b0)
      fail("R12 reset state", {active, main_pulse, ref_pulse, pump_up, pump_dn}, 0);
    mon_on = 1'b1;
    // R10: ticks while idle leave every output low (monitor reports strays).
    rf_tick = 1'b1;
    ref_q = 1; ref_base = 0; ref_on = 1'b1;
    repeat (3000) @(negedge clk);
    n_chk++;
    if (active !== 1'b0) fail("R10 idle active", active, 0);
    ref_on = 1'b0;
    // R5 R11: main first, disable during a sink pulse, ratio 4.
    scen(0, 2'b00, 544, 20, 3, 0, 0, 6);
    // R6 R3: reference first, ratio 16, main offset changed mid-run.
    scen(0, 2'b01, 136, -12, 5, 2, 5, 4);
    // R7: coincident terminal counts, ratio 8.
    scen(0, 2'b10, 272, 0, 2, 0, 0, 2);
    // R1 R2: nonzero offset, ratio 12.
    scen(8, 2'b11, 182, 7, 2, 0, 0, 9);
    // R1: largest offset (2303), growing sink pulses, disable right after start of one.
    scen(127, 2'b00, 576, 3, 2, 0, 0, 1);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
      $finish;
    end
  end

endmodule